// File: doc/BRIEF.md
# Chip Erase Sequencer

This block wipes a device on command from a debug or control port. Software or a debugger writes a one to the start bit of the control register. The sequencer then clears three regions one after another, each through a request/acknowledge handshake toward that region's memory model. The volatile memories are cleared first, then the main nonvolatile array, and the protection state last. The user page has no clear request at all, so its contents survive the erase.

Progress is visible in a status register. A busy flag stays high while the sequence runs. A done flag rises once the protection state has been acknowledged. An error flag rises if a region does not acknowledge within a programmable wait window. After the sequence ends, either way, the block accepts no further start commands until it is reset, because the device must be restarted before it can be used normally.

Top module: `erase_seq`

## Requirements
- R1: A register write to address 0 with bit 0 of the write data set, while the block is idle, raises `clr_req[0]` in the next cycle. `sts_busy` then stays high until the sequence ends.
- R2: Requests are issued in a fixed order: `clr_req[0]` (volatile), then `clr_req[1]` (main array), then `clr_req[2]` (protection state). Each request follows only after the acknowledge bit of the phase before it has been seen. Acknowledge bits of other phases are ignored.
- R3: Each request is high for exactly one cycle, and at most one bit of `clr_req` is high at any time.
- R4: The user page is never cleared. No request exists for it, and a model of its contents is unchanged after any erase.
- R5: An acknowledge on `clr_ack[2]` while waiting in the last phase sets `sts_done` and clears `sts_busy` in the next cycle.
- R6: Once the sequence has ended (done or error), start writes have no effect and the status holds until reset.
- R7: A start write while busy is ignored. It causes no restart and no extra request.
- R8: The acknowledge window is max(limit,1) cycles, starting in the cycle after a request. An acknowledge in the last cycle of the window is accepted. If no acknowledge arrives, `sts_err` is set in the next cycle, `sts_busy` falls, `sts_done` stays low, and no further request is issued.
- R9: The wait limit register at address 1 can be written and read back. It resets to DEF_LIMIT (64), and writes to it while busy are ignored.
- R10: Reset clears done, busy and error. The status register at address 2 reads done in bit 0, busy in bit 1 and error in bit 2; address 0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | DATA_W (16) | Register write data |
| reg_rdata | output | DATA_W (16) | Read data for `reg_addr`, combinational |
| clr_req | output | 3 | One-cycle clear requests: bit 0 volatile, bit 1 main, bit 2 protection |
| clr_ack | input | 3 | Acknowledge pulses, same bit order as the requests |
| sts_done | output | 1 | Sequence completed |
| sts_busy | output | 1 | Sequence running |
| sts_err | output | 1 | Acknowledge timeout occurred |

## Verification
Two events can fall in the same cycle: a region acknowledge and the expiry of the wait window. The bench provokes this by acknowledging in exactly the last window cycle, with limits of 0, 1 and larger values. The rule is that the acknowledge wins, so the next request or done must appear, not the error. A second collision is a start write or a limit write landing during a running sequence. The bench judges this by the absence of a repeated volatile request and by reading back the unchanged limit after the sequence ends.

// File: rtl/erase_pkg.sv
// Shared definitions for the chip erase sequencer: register map and states.
package erase_pkg;
    localparam int NPHASE = 3;
    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_LIMIT = 2'd1;
    localparam logic [1:0] ADR_STAT  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } seq_state_t;
endpackage

// File: rtl/erase_regs.sv
// Register decode for the erase sequencer.
// It produces a start strobe, holds the wait limit and muxes the read data.
// Assumes a single shared address for reads and writes; reads are combinational.
module erase_regs
    import erase_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int TMO_W     = 16,
    parameter int DEF_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              err,
    output logic              start,
    output logic [TMO_W-1:0]  limit,
    output logic [DATA_W-1:0] rdata
);
    localparam int LW = (TMO_W < DATA_W) ? TMO_W : DATA_W;

    // Start strobe: write of bit 0 to the control address.
    always_comb start = wr && (addr == ADR_CTRL) && wdata[0];

    // Wait limit register; frozen while a sequence is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= TMO_W'(DEF_LIMIT);
        else if (wr && addr == ADR_LIMIT && !busy)
            limit <= TMO_W'(wdata[LW-1:0]);
    end

    // Read mux over the three mapped registers.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_LIMIT: rdata[LW-1:0] = limit[LW-1:0];
            ADR_STAT:  rdata[2:0]    = {err, busy, done};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/erase_timer.sv
// Acknowledge wait timer.
// It counts wait cycles and flags the last cycle of the window.
// Assumes en is high only in wait cycles; a limit of 0 behaves as 1.
module erase_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TMO_W-1:0] limit,
    output logic             last
);
    logic [TMO_W-1:0] cnt;

    // Count cycles spent waiting; restart whenever not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Last window cycle: count+1 has reached the limit.
    always_comb last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/erase_fsm.sv
// Phase sequencer for the chip erase.
// It issues one-cycle clear requests in fixed order and waits for each acknowledge.
// A start is accepted only from idle; the done and fail states are terminal until reset.
module erase_fsm
    import erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPHASE-1:0] ack,
    input  logic              last,
    output logic [NPHASE-1:0] req,
    output logic              waiting,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int PH_W = $clog2(NPHASE);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(NPHASE - 1);

    seq_state_t     state, state_n;
    logic [PH_W-1:0] phase, phase_n;

    // State and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
        end else begin
            state <= state_n;
            phase <= phase_n;
        end
    end

    // Next-state logic: the acknowledge has priority over window expiry.
    always_comb begin
        state_n = state;
        phase_n = phase;
        case (state)
            ST_IDLE: if (start) begin
                state_n = ST_REQ;
                phase_n = '0;
            end
            ST_REQ: state_n = ST_WAIT;
            ST_WAIT: begin
                if (ack[phase]) begin
                    if (phase == PH_LAST) begin
                        state_n = ST_DONE;
                    end else begin
                        state_n = ST_REQ;
                        phase_n = phase + 1'b1;
                    end
                end else if (last) begin
                    state_n = ST_FAIL;
                end
            end
            default: state_n = state;
        endcase
    end

    // Request decode: one bit for the current phase during the request cycle.
    always_comb begin
        req = '0;
        if (state == ST_REQ) req[phase] = 1'b1;
    end

    // Status flags derived from the state.
    always_comb begin
        waiting = (state == ST_WAIT);
        busy    = (state == ST_REQ) || (state == ST_WAIT);
        done    = (state == ST_DONE);
        err     = (state == ST_FAIL);
    end
endmodule

// File: rtl/erase_seq.sv
// Chip erase sequencer top.
// It ties the register decode, the phase sequencer and the wait timer together.
// Assumes the clear acknowledges are synchronous pulses from the region models.
module erase_seq
    import erase_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int TMO_W     = 16,
    parameter int DEF_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [2:0]        clr_req,
    input  logic [2:0]        clr_ack,
    output logic              sts_done,
    output logic              sts_busy,
    output logic              sts_err
);
    logic             start;
    logic             waiting;
    logic             last;
    logic [TMO_W-1:0] limit;

    erase_regs #(.DATA_W(DATA_W), .TMO_W(TMO_W), .DEF_LIMIT(DEF_LIMIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(sts_busy), .done(sts_done), .err(sts_err),
        .start(start), .limit(limit), .rdata(reg_rdata)
    );

    erase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ack(clr_ack), .last(last),
        .req(clr_req), .waiting(waiting), .busy(sts_busy), .done(sts_done), .err(sts_err)
    );

    erase_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(waiting), .limit(limit), .last(last)
    );
endmodule

// File: rtl/erase_seq_chk.sv
// Protocol checker for erase_seq, bound to every instance.
// It observes ports only and keeps a flag of its own for ordering.
module erase_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        wd0,
    input logic [2:0]  clr_req,
    input logic [2:0]  clr_ack,
    input logic        sts_done,
    input logic        sts_busy,
    input logic        sts_err
);
    logic vol_seen;

    // Remember that the volatile region acknowledged during this run.
    always_ff @(posedge clk) begin
        if (!rst_n)                   vol_seen <= 1'b0;
        else if (sts_busy && clr_ack[0]) vol_seen <= 1'b1;
    end

    a_r1_start_req: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && wd0 && !sts_busy && !sts_done && !sts_err)
        |=> (clr_req == 3'b001));
    a_r2_main_after_vol: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req[1] |-> vol_seen);
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_req));
    a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_req) |=> !(|clr_req));
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_done && sts_busy));
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sts_done |=> (sts_done && !sts_busy && clr_req == 3'b000));
    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sts_err |=> (sts_err && !sts_done && clr_req == 3'b000));
endmodule

bind erase_seq erase_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .wd0(reg_wdata[0]),
    .clr_req(clr_req), .clr_ack(clr_ack), .sts_done(sts_done), .sts_busy(sts_busy),
    .sts_err(sts_err)
);

// File: tb/sim_erase_seq.sv
`timescale 1ns/1ps
module sim_erase_seq;
    localparam int DW = 16;
    localparam int DEF = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [2:0]    clr_req;
    logic [2:0]    clr_ack = 3'b000;
    logic          sts_done, sts_busy, sts_err;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] m_vol, m_main, m_prot, m_up, up_ref;

    erase_seq u0 (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Region models: a request wipes its region; the user page has no request.
    always @(negedge clk) begin
        if (clr_req[0]) m_vol  = 8'h00;
        if (clr_req[1]) m_main = 8'h00;
        if (clr_req[2]) m_prot = 8'h00;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int window(input int lim);
        return (lim == 0) ? 1 : lim;
    endfunction

    function automatic int status_exp(input bit d, input bit b, input bit e);
        return {29'd0, e, b, d};
    endfunction

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic [1:0] a, input int v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = DW'(v);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; reg_wr = 1'b0; clr_ack = 3'b000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_vol = 8'($urandom_range(1, 255)); m_main = 8'($urandom_range(1, 255));
        m_prot = 8'($urandom_range(1, 255)); m_up = 8'($urandom_range(1, 255));
        up_ref = m_up;
    endtask

    // One full erase with per-phase acknowledge delays d[] (wait cycles before ack).
    task automatic run(input int lim, input int d0, input int d1, input int d2, input bit stray);
        int d[3];
        int v, w, win;
        bit timed;
        d[0] = d0; d[1] = d1; d[2] = d2;
        win = window(lim);
        timed = 1'b0;
        wr(2'd1, lim);
        rd(2'd1, v);
        check(v == lim, "R9 limit readback", v, lim);
        rd(2'd2, v);
        check(v == 0, "R10 idle status", v, 0);
        wr(2'd0, 1);
        for (int p = 0; p < 3 && !timed; p++) begin
            // Now in the request cycle of phase p.
            check(clr_req == 3'(1 << p), p == 0 ? "R1 first request" : "R2 next request in order",
                  int'(clr_req), 1 << p);
            check(sts_busy && !sts_done, "R1 busy during sequence", int'(sts_busy), 1);
            if (stray && p == 0) begin
                reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;   // R7 start while busy
            end else if (stray && p == 1) begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h00EE;   // R9 limit write while busy
            end
            @(negedge clk);
            reg_wr = 1'b0;
            check(clr_req == 3'b000, "R3 request lasts one cycle", int'(clr_req), 0);
            for (w = 0; ; w++) begin
                if (w == d[p] && d[p] < win) begin
                    clr_ack = 3'(1 << p);
                    @(negedge clk);
                    clr_ack = 3'b000;
                    break;
                end
                clr_ack = 3'($urandom_range(0, 7)) & ~3'(1 << p);   // R2 foreign acks ignored
                if (w == win - 1) begin
                    @(negedge clk);
                    clr_ack = 3'b000;
                    timed = 1'b1;
                    break;
                end
                @(negedge clk);
                clr_ack = 3'b000;
                check(clr_req == 3'b000 && sts_busy, "R7 R2 no extra request while waiting",
                      int'(clr_req), 0);
            end
        end
        rd(2'd2, v);
        if (timed) begin
            check(v == status_exp(0, 0, 1), "R8 timeout sets error", v, status_exp(0, 0, 1));
        end else begin
            check(v == status_exp(1, 0, 0), "R5 done after last ack", v, status_exp(1, 0, 0));
            check(m_vol == 0 && m_main == 0 && m_prot == 0, "R2 all regions cleared",
                  int'({m_vol, m_main, m_prot}), 0);
        end
        check(m_up == up_ref, "R4 user page kept", int'(m_up), int'(up_ref));
        rd(2'd1, v);
        check(v == lim, "R9 limit unchanged by write while busy", v, lim);
        // R6: start write after the end has no effect.
        wr(2'd0, 1);
        for (int k = 0; k < 4; k++) begin
            check(clr_req == 3'b000, "R6 no request after end", int'(clr_req), 0);
            @(negedge clk);
        end
        rd(2'd2, v);
        check(v == (timed ? status_exp(0, 0, 1) : status_exp(1, 0, 0)), "R6 status holds",
              v, timed ? status_exp(0, 0, 1) : status_exp(1, 0, 0));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        begin
            int v;
            rd(2'd1, v); check(v == DEF, "R9 limit reset value", v, DEF);
            rd(2'd2, v); check(v == 0, "R10 status after reset", v, 0);
            rd(2'd0, v); check(v == 0, "R10 control reads zero", v, 0);
        end
        // Directed: acknowledge in the last window cycle (R8 collision, ack wins).
        do_reset(); run(4, 3, 3, 3, 1'b1);
        do_reset(); run(1, 0, 0, 0, 1'b0);
        do_reset(); run(0, 0, 0, 0, 1'b1);
        // Directed: window expires in the main array phase (R8).
        do_reset(); run(3, 1, 3, 0, 1'b0);
        // Directed: expiry in the first phase with limit 0 (R8).
        do_reset(); run(0, 1, 0, 0, 1'b0);
        // Random mix.
        for (int t = 0; t < 40; t++) begin
            int lim, win;
            int dd[3];
            lim = (($urandom_range(0, 9)) == 0) ? 0 : int'($urandom_range(1, 7));
            win = window(lim);
            for (int p = 0; p < 3; p++)
                dd[p] = ($urandom_range(0, 7) == 0) ? win : int'($urandom_range(0, win - 1));
            do_reset();
            run(lim, dd[0], dd[1], dd[2], 1'($urandom_range(0, 1)));
        end
        // R10: reset from a finished state clears the flags.
        do_reset();
        begin
            int v;
            rd(2'd2, v); check(v == 0, "R10 reset clears done and error", v, 0);
        end
        summary();
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        wait (cyc > 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        summary();
    end
endmodule